// File: doc/BRIEF.md
# Decimal Digit-Product Partial Product Generator

This combinational block forms the two decimal partial products that one BCD multiplier digit produces against an N-digit BCD multiplicand. Each multiplicand digit is multiplied by the multiplier digit as an ordinary 4-bit by 4-bit unsigned binary product. The result is at most 81. Each such product is then converted on its own into a tens digit and a units digit. No carry passes between digit positions.

The units digits are gathered into a low word of N BCD digits. The tens digits are gathered into a high word of N BCD digits. Digit i of the high word carries weight 10^(i+1), so the high word is worth ten times its face value relative to the low word. A downstream adder or reduction tree sums low + 10*high to obtain the multiplicand times the digit. That adder is not part of this block.

A parameter selects how the binary-to-decimal correction is built. One option multiplies by a fixed-point reciprocal of ten. The other counts threshold comparisons. Both options give identical outputs.

Top module: `bcd_pp_gen`

## Requirements
- R1: Low word digit i (bits 4i+3..4i) equals (a_i * b) mod 10, where a_i is multiplicand digit i (bits 4i+3..4i) and b is the multiplier digit.
- R2: High word digit i (bits 4i+3..4i) equals floor(a_i * b / 10) and carries weight 10^(i+1).
- R3: For BCD inputs, every low word digit lies in 0..9 and every high word digit lies in 0..8.
- R4: The value of the low word plus ten times the value of the high word, both read as BCD integers, equals the multiplicand value times b.
- R5: Multiplier digit 0 drives both words to all zeros.
- R6: Multiplier digit 1 makes the low word equal to the multiplicand and drives the high word to all zeros.
- R7: CORR_STYLE 0 (reciprocal multiply) and CORR_STYLE 1 (threshold count) produce identical words for every BCD input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_i | input | 4*N_DIGITS | BCD multiplicand. Digit i occupies bits 4i+3..4i. |
| mdigit_i | input | 4 | BCD multiplier digit, 0..9. |
| lo_word_o | output | 4*N_DIGITS | Units digits of the per-digit products, weight 10^i. |
| hi_word_o | output | 4*N_DIGITS | Tens digits of the per-digit products, weight 10^(i+1). |

## Verification
The block holds no state, so a faulty correction or wiring fault appears at the ports in the same cycle that the inputs are applied. Each fault affects only the digit positions whose product falls in the faulty range. A wrong tens or units split shows either as a digit above 9, or as a recombined low + 10*high that differs from the arithmetic product. A swapped or misaligned lane shows only for multiplicands whose digits differ from one another. For that reason, the sweep uses uniform-digit multiplicands for every product value, and then adds random mixed-digit multiplicands.

// File: rtl/bcd_pp_pkg.sv
package bcd_pp_pkg;
   localparam int DIGIT_W = 4;
   localparam int PROD_W  = 7;

   typedef logic [DIGIT_W-1:0] bcd_t;
   typedef logic [PROD_W-1:0]  dprod_t;

   typedef struct packed {
      bcd_t tens;
      bcd_t units;
   } dec_pair_t;
endpackage

// File: rtl/bcd_pp_digit_mul.sv
module bcd_pp_digit_mul
   import bcd_pp_pkg::*;
(
   input  bcd_t   a_i,
   input  bcd_t   b_i,
   output dprod_t prod_o
);
   logic [2*DIGIT_W-1:0] full;

   always_comb begin
      full   = a_i * b_i;
      prod_o = full[PROD_W-1:0];
   end

   always_comb begin
      if (a_i <= 4'd9 && b_i <= 4'd9) begin
         AST_PROD_RANGE: assert (prod_o <= 7'd81 && full[2*DIGIT_W-1:PROD_W] == '0)
            else $error("digit product out of range"); // R2
      end
   end
endmodule

// File: rtl/bcd_pp_bin2bcd.sv
module bcd_pp_bin2bcd
   import bcd_pp_pkg::*;
#(
   parameter int CORR_STYLE = 0
)(
   input  dprod_t    prod_i,
   output dec_pair_t pair_o
);
   localparam int RECIP_MUL   = 205;
   localparam int RECIP_SHIFT = 11;
   localparam int MUL_W       = PROD_W + 8;
   localparam int MAX_TENS    = 8;

   initial begin
      assert (CORR_STYLE == 0 || CORR_STYLE == 1)
         else $error("CORR_STYLE must be 0 or 1");
   end

   bcd_t tens_q;

   generate
      if (CORR_STYLE == 0) begin : g_recip
         logic [MUL_W-1:0] scaled;
         always_comb begin
            scaled = MUL_W'(prod_i) * MUL_W'(RECIP_MUL);
            tens_q = scaled[RECIP_SHIFT +: DIGIT_W];
         end
      end else begin : g_thresh
         always_comb begin
            tens_q = '0;
            for (int k = 1; k <= MAX_TENS; k++) begin
               if (prod_i >= PROD_W'(10 * k)) tens_q = tens_q + 4'd1;
            end
         end
      end
   endgenerate

   dprod_t tens_x10;

   always_comb begin
      tens_x10     = {tens_q[3:0], 3'b000} + {2'b00, tens_q[3:0], 1'b0};
      pair_o.tens  = tens_q;
      pair_o.units = DIGIT_W'(prod_i - tens_x10);
   end

   always_comb begin
      if (prod_i <= 7'd81) begin
         AST_UNITS_BCD: assert (pair_o.units <= 4'd9)
            else $error("units digit not BCD"); // R3
         AST_TENS_MAX: assert (pair_o.tens <= 4'd8)
            else $error("tens digit above 8"); // R3
         AST_RECOMBINE: assert (7'(pair_o.tens) * 7'd10 + 7'(pair_o.units) == prod_i)
            else $error("tens/units do not recombine"); // R4
      end
   end
endmodule

// File: rtl/bcd_pp_gen.sv
module bcd_pp_gen
   import bcd_pp_pkg::*;
#(
   parameter int N_DIGITS   = 8,
   parameter int CORR_STYLE = 0
)(
   input  logic [DIGIT_W*N_DIGITS-1:0] mcand_i,
   input  logic [DIGIT_W-1:0]          mdigit_i,
   output logic [DIGIT_W*N_DIGITS-1:0] lo_word_o,
   output logic [DIGIT_W*N_DIGITS-1:0] hi_word_o
);
   localparam int WORD_W = DIGIT_W * N_DIGITS;

   initial begin
      assert (N_DIGITS >= 1 && N_DIGITS <= 64)
         else $error("N_DIGITS out of supported range");
   end

   genvar gi;
   generate
      for (gi = 0; gi < N_DIGITS; gi++) begin : g_lane
         dprod_t    lane_prod;
         dec_pair_t lane_pair;

         bcd_pp_digit_mul u_mul (
            .a_i    (mcand_i[DIGIT_W*gi +: DIGIT_W]),
            .b_i    (mdigit_i),
            .prod_o (lane_prod)
         );

         bcd_pp_bin2bcd #(.CORR_STYLE(CORR_STYLE)) u_corr (
            .prod_i (lane_prod),
            .pair_o (lane_pair)
         );

         assign lo_word_o[DIGIT_W*gi +: DIGIT_W] = lane_pair.units;
         assign hi_word_o[DIGIT_W*gi +: DIGIT_W] = lane_pair.tens;
      end
   endgenerate

   always_comb begin
      if (mdigit_i == 4'd0) begin
         AST_ZERO_DIGIT: assert (lo_word_o == '0 && hi_word_o == '0)
            else $error("digit 0 gave nonzero words"); // R5
      end
      if (mdigit_i == 4'd1) begin
         AST_UNIT_DIGIT: assert (lo_word_o == mcand_i && hi_word_o == WORD_W'(0))
            else $error("digit 1 did not pass multiplicand"); // R6
      end
   end
endmodule

// File: tb/bcd_pp_gen_bench.sv
module bcd_pp_gen_bench;
   localparam int  N       = 6;
   localparam int  W       = 4 * N;
   localparam time CLK_P   = 10ns;
   localparam int  N_RAND  = 1500;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] mcand = '0;
   logic [3:0]   mdig  = '0;
   logic [W-1:0] lo_a, hi_a, lo_b, hi_b;
   int           nvec = 0;
   int           nbad = 0;
   bit           done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   bcd_pp_gen #(.N_DIGITS(N), .CORR_STYLE(0)) u_bcd_pp_gen (
      .mcand_i(mcand), .mdigit_i(mdig), .lo_word_o(lo_a), .hi_word_o(hi_a));

   bcd_pp_gen #(.N_DIGITS(N), .CORR_STYLE(1)) u_bcd_pp_gen_alt (
      .mcand_i(mcand), .mdigit_i(mdig), .lo_word_o(lo_b), .hi_word_o(hi_b));

   function automatic longint bcd_val(input logic [W-1:0] w);
      longint v = 0;
      for (int i = N - 1; i >= 0; i--) v = v * 10 + longint'(w[4*i +: 4]);
      return v;
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%0d expected=%0d (mcand=%h digit=%0d)",
                  req, act, exp, mcand, mdig);
      end
   endtask

   task automatic check_pair(input logic [W-1:0] lo, input logic [W-1:0] hi);
      for (int i = 0; i < N; i++) begin
         int p = int'(mcand[4*i +: 4]) * int'(mdig);
         chk("R1", longint'(lo[4*i +: 4]), longint'(p % 10));
         chk("R2", longint'(hi[4*i +: 4]), longint'(p / 10));
         chk("R3", longint'(lo[4*i +: 4] > 4'd9 || hi[4*i +: 4] > 4'd8), 0);
      end
      chk("R4", bcd_val(lo) + 10 * bcd_val(hi), bcd_val(mcand) * longint'(mdig));
      if (mdig == 4'd0) chk("R5", longint'(lo | hi), 0);
      if (mdig == 4'd1) begin
         chk("R6", longint'(lo), longint'(mcand));
         chk("R6", longint'(hi), 0);
      end
   endtask

   task automatic apply(input logic [W-1:0] mc, input logic [3:0] d);
      @(posedge clk);
      mcand = mc;
      mdig  = d;
      @(negedge clk);
      check_pair(lo_a, hi_a);
      check_pair(lo_b, hi_b);
      chk("R7", longint'(lo_a), longint'(lo_b));
      chk("R7", longint'(hi_a), longint'(hi_b));
   endtask

   function automatic logic [W-1:0] rand_bcd();
      logic [W-1:0] w;
      for (int i = 0; i < N; i++) w[4*i +: 4] = 4'($urandom % 10);
      return w;
   endfunction

   function automatic logic [W-1:0] uniform(input int k);
      logic [W-1:0] w;
      for (int i = 0; i < N; i++) w[4*i +: 4] = 4'(k);
      return w;
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R5", longint'(lo_a | hi_a | lo_b | hi_b), 0);
      rst = 1'b0;
      for (int d = 0; d < 10; d++)
         for (int k = 0; k < 10; k++)
            apply(uniform(k), 4'(d));
      for (int d = 0; d < 10; d++) begin
         apply(W'(24'h123456), 4'(d));
         apply(W'(24'h908070), 4'(d));
      end
      for (int n = 0; n < N_RAND; n++)
         apply(rand_bcd(), 4'($urandom % 10));
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end
endmodule